// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Link

This block carries one logic level in a single direction across a barrier without sending the level itself. The sending side cleans up its input with a minimum-width filter. It then turns every filtered rising edge into a one-cycle pulse on a set line and every filtered falling edge into a one-cycle pulse on a clear line. When the input stays quiet, the sending side repeats the pulse that matches the present level at a fixed interval. A receiver that missed a pulse, or started late, therefore still settles to the right value.

The receiving side is a set/clear latch driven by the two pulse lines. It also has a watchdog that counts cycles since the last pulse of either kind. When the count runs out, it forces the output to its default high level, which models a dead or unpowered sending side. A `tx_enable` input models power on the sending side: while it is low, nothing is sent. Each side has its own synchronous active-low reset. All timing is in clock cycles and set by parameters. At a 125 MHz clock the defaults are a 40 ns minimum pulse width, a refresh period of about 1.7 µs and a watchdog time of 5 µs. The sending side never raises both lines in one cycle. If both are ever high together, the receiver lets set win.

Top module: `iso_pulse_link`

## Requirements
- R1: While `rx_rst_n` is low, `dout` is 1. While `tx_rst_n` is low, `pulse_set` and `pulse_clr` are 0. After both resets are released with `din` at 0, `dout` stays 1 and no pulse appears before the first refresh described in R6.
- R2: A filtered rising edge of `din` produces exactly one cycle of `pulse_set`=1, and a filtered falling edge exactly one cycle of `pulse_clr`=1. The pulse is visible after the (MIN_PW_CYC+2)-th rising clock edge that follows the change on `din`.
- R3: `dout` becomes 1 on the clock edge after a `pulse_set` cycle and 0 on the clock edge after a `pulse_clr` cycle, and it holds its value otherwise. A `din` change therefore reaches `dout` at the (MIN_PW_CYC+3)-th rising edge.
- R4: A `din` excursion held for fewer than MIN_PW_CYC sampled cycles produces no pulse and no change on `dout`. An excursion of exactly MIN_PW_CYC cycles passes, and its width is preserved.
- R5: While enabled and with `din` steady, a pulse matching the present level (`pulse_set` for 1, `pulse_clr` for 0) repeats exactly every REFRESH_CYC cycles after the previous pulse. A real edge restarts this interval, and refresh never emits the opposite line.
- R6: After the sending side leaves reset, or after `tx_enable` rises, the pulse for the present level appears after the REFRESH_CYC-th rising edge.
- R7: While `tx_enable` is 0, neither pulse line is ever 1. `din` changes made during that time are not reported.
- R8: If the receiver takes in no pulse for WDOG_CYC cycles, `dout` is forced to 1. This happens at the (WDOG_CYC+1)-th rising edge after the edge that raised the last pulse on the ports. Until then `dout` holds its value, and afterwards it stays 1 until a new pulse arrives.
- R9: A `pulse_clr` received while the watchdog has expired drives `dout` to 0 on the next edge.
- R10: `pulse_set` and `pulse_clr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| tx_rst_n | input | 1 | Synchronous active-low reset, sending side |
| rx_rst_n | input | 1 | Synchronous active-low reset, receiving side |
| tx_enable | input | 1 | 1 = sending side powered; 0 = no pulses sent |
| din | input | 1 | Level to be carried across |
| pulse_set | output | 1 | One-cycle pulse: level is high |
| pulse_clr | output | 1 | One-cycle pulse: level is low |
| dout | output | 1 | Received level, default high |

## Verification
The hardest state to reach is the expired watchdog. Normal traffic never gets there, because a refresh always arrives well inside the watchdog window. The stimulus drops `tx_enable` right after a clear pulse, toggles `din` while disabled to show that nothing leaks out, and counts cycles from that last pulse to the exact edge where `dout` is forced high. It then re-enables the sending side with `din` low, so the first refresh is a clear pulse landing on an expired receiver.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

   // One pulse word as it crosses the barrier
   typedef struct packed {
      logic set;
      logic clr;
   } iso_pulse_t;

   // Counter width for a counter that runs from 0 to n-1
   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/iso_glitch_filter.sv
module iso_glitch_filter #(
   parameter int unsigned MIN_PW_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic filt_out
);
   localparam int unsigned CW = iso_link_pkg::cnt_width(MIN_PW_CYC);

   if (MIN_PW_CYC == 0) begin : g_bad_width
      $error("MIN_PW_CYC must be at least 1");
   end

   logic smp;

   always_ff @(posedge clk) begin
      if (!rst_n) smp <= 1'b0;
      else        smp <= raw_in;
   end

   if (MIN_PW_CYC <= 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n) filt_out <= 1'b0;
         else        filt_out <= smp;
      end
   end else begin : g_count
      logic [CW-1:0] run;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            filt_out <= 1'b0;
            run      <= '0;
         end else if (smp == filt_out) begin
            run <= '0;
         end else if (run == CW'(MIN_PW_CYC - 1)) begin
            filt_out <= smp;
            run      <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end

   // R4: the filtered level only ever moves to the value just sampled
   p_filt_from_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_out) |-> (filt_out == $past(smp)));

endmodule

// File: rtl/iso_edge_tx.sv
module iso_edge_tx #(
   parameter int unsigned REFRESH_CYC = 212
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     level,
   output iso_link_pkg::iso_pulse_t pulse
);
   localparam int unsigned RW = iso_link_pkg::cnt_width(REFRESH_CYC);

   if (REFRESH_CYC < 2) begin : g_bad_refresh
      $error("REFRESH_CYC must be at least 2");
   end

   logic          level_d;
   logic [RW-1:0] idle;
   logic          edge_seen;
   logic          refresh_due;

   assign edge_seen   = (level != level_d);
   assign refresh_due = (idle == RW'(REFRESH_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         idle  <= '0;
         pulse <= '0;
      end else if (edge_seen || refresh_due) begin
         idle      <= '0;
         pulse.set <= level;
         pulse.clr <= ~level;
      end else begin
         idle  <= idle + 1'b1;
         pulse <= '0;
      end
   end

   // R10: both lines never high together
   p_set_clr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse.set && pulse.clr));

   // R7: a disabled sender is silent
   p_silent_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!pulse.set && !pulse.clr));

   // R2: a set pulse lasts a single cycle
   p_set_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.set |=> !pulse.set);

   // R2: a clear pulse lasts a single cycle
   p_clr_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.clr |=> !pulse.clr);

endmodule

// File: rtl/iso_latch_rx.sv
module iso_latch_rx #(
   parameter int unsigned WDOG_CYC = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_in,
   input  logic clr_in,
   output logic dout
);
   localparam int unsigned WW = iso_link_pkg::cnt_width(WDOG_CYC);

   if (WDOG_CYC < 2) begin : g_bad_wdog
      $error("WDOG_CYC must be at least 2");
   end

   logic [WW-1:0] quiet;
   logic          expired;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= 1'b1;
         quiet   <= '0;
         expired <= 1'b0;
      end else if (set_in) begin
         dout    <= 1'b1;
         quiet   <= '0;
         expired <= 1'b0;
      end else if (clr_in) begin
         dout    <= 1'b0;
         quiet   <= '0;
         expired <= 1'b0;
      end else if (!expired) begin
         if (quiet == WW'(WDOG_CYC - 1)) begin
            dout    <= 1'b1;
            expired <= 1'b1;
         end else begin
            quiet <= quiet + 1'b1;
         end
      end
   end

   // Independent count of cycles since the last pulse, for the checks below
   logic [WW-1:0] chk_idle;
   always_ff @(posedge clk) begin
      if (!rst_n || set_in || clr_in)            chk_idle <= '0;
      else if (chk_idle != WW'(WDOG_CYC - 1))    chk_idle <= chk_idle + 1'b1;
   end

   // R3: set drives the output high
   p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_in |=> dout);

   // R3, R9: clear alone drives the output low
   p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_in && !set_in) |=> !dout);

   // R8: output rises only from a set pulse or a full quiet window
   p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout) |-> ($past(set_in) || ($past(chk_idle) == WW'(WDOG_CYC - 1))));

   // R3: output never falls without a clear pulse
   p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout) |-> $past(clr_in));

endmodule

// File: rtl/iso_pulse_link.sv
module iso_pulse_link #(
   parameter int unsigned MIN_PW_CYC  = 5,
   parameter int unsigned REFRESH_CYC = 212,
   parameter int unsigned WDOG_CYC    = 625
) (
   input  logic clk,
   input  logic tx_rst_n,
   input  logic rx_rst_n,
   input  logic tx_enable,
   input  logic din,
   output logic pulse_set,
   output logic pulse_clr,
   output logic dout
);
   if (REFRESH_CYC >= WDOG_CYC) begin : g_bad_ratio
      $error("REFRESH_CYC must be shorter than WDOG_CYC");
   end

   logic                     filt_lvl;
   iso_link_pkg::iso_pulse_t tx_pulse;

   iso_glitch_filter #(.MIN_PW_CYC(MIN_PW_CYC)) filt_i (
      .clk      (clk),
      .rst_n    (tx_rst_n),
      .raw_in   (din),
      .filt_out (filt_lvl)
   );

   iso_edge_tx #(.REFRESH_CYC(REFRESH_CYC)) tx_i (
      .clk    (clk),
      .rst_n  (tx_rst_n),
      .enable (tx_enable),
      .level  (filt_lvl),
      .pulse  (tx_pulse)
   );

   assign pulse_set = tx_pulse.set;
   assign pulse_clr = tx_pulse.clr;

   iso_latch_rx #(.WDOG_CYC(WDOG_CYC)) rx_i (
      .clk    (clk),
      .rst_n  (rx_rst_n),
      .set_in (pulse_set),
      .clr_in (pulse_clr),
      .dout   (dout)
   );

endmodule

// File: tb/iso_pulse_link_tb_top.sv
module iso_pulse_link_tb_top;
   localparam int M = 5;
   localparam int R = 212;
   localparam int W = 625;
   localparam int NV = 12;

   // din, hold ticks, expected dout, cumulative sets, cumulative clears
   localparam int TBL [NV][5] = '{
      '{1, 12, 1, 1, 0},
      '{0, 12, 0, 1, 1},
      '{1,  4, 0, 1, 1},   // R4 glitch of 4 rejected
      '{0, 12, 0, 1, 1},
      '{1,  5, 0, 1, 1},   // R4 exact width passes
      '{0, 14, 0, 2, 2},
      '{1,  3, 0, 2, 2},   // R4 glitch
      '{0,  2, 0, 2, 2},
      '{1, 12, 1, 3, 2},
      '{0,  1, 1, 3, 2},   // R4 low glitch
      '{1, 12, 1, 3, 2},
      '{0, 12, 0, 3, 3}
   };

   logic clk = 1'b0;
   logic tx_rst_n = 1'b0;
   logic rx_rst_n = 1'b0;
   logic tx_enable = 1'b1;
   logic din = 1'b0;
   logic pulse_set, pulse_clr, dout;

   int tests = 0;
   int fails = 0;
   int nclk = 0;
   int n_set = 0;
   int n_clr = 0;
   int last_set_t = 0;
   int last_clr_t = 0;
   int excl_cnt = 0;

   always #4 clk = ~clk;

   iso_pulse_link #(.MIN_PW_CYC(M), .REFRESH_CYC(R), .WDOG_CYC(W)) dut_i (
      .clk       (clk),
      .tx_rst_n  (tx_rst_n),
      .rx_rst_n  (rx_rst_n),
      .tx_enable (tx_enable),
      .din       (din),
      .pulse_set (pulse_set),
      .pulse_clr (pulse_clr),
      .dout      (dout)
   );

   always @(negedge clk) begin
      if (pulse_set && pulse_clr) excl_cnt++;
   end

   task automatic tick();
      @(negedge clk);
      nclk++;
      if (pulse_set) begin n_set++; last_set_t = nclk; end
      if (pulse_clr) begin n_clr++; last_clr_t = nclk; end
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      #(200000 * 8);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int s0, c0, t, k, lows, clr0, lp, pc, te;
      int times [8];

      // R1 reset state
      repeat (4) tick();
      check(dout == 1'b1, "R1 dout in reset", dout, 1);
      check(n_set + n_clr == 0, "R1 no pulse in reset", n_set + n_clr, 0);

      // R6 first refresh after release
      tx_rst_n = 1'b1;
      rx_rst_n = 1'b1;
      for (int i = 0; i < R - 1; i++) tick();
      check(n_set + n_clr == 0, "R1 quiet before first refresh", n_set + n_clr, 0);
      check(dout == 1'b1, "R1 dout after release", dout, 1);
      tick();
      check(pulse_clr == 1'b1, "R6 refresh after reset", pulse_clr, 1);
      tick();
      check(dout == 1'b0, "R3 dout after clear", dout, 0);

      // Vector table: R2 R3 R4
      s0 = n_set;
      c0 = n_clr;
      for (int e = 0; e < NV; e++) begin
         din = TBL[e][0][0];
         repeat (TBL[e][1]) tick();
         check(dout == TBL[e][2][0], $sformatf("R3 table entry %0d dout", e), dout, TBL[e][2]);
         check(n_set - s0 == TBL[e][3], $sformatf("R2 table entry %0d sets", e), n_set - s0, TBL[e][3]);
         check(n_clr - c0 == TBL[e][4], $sformatf("R2 table entry %0d clears", e), n_clr - c0, TBL[e][4]);
      end

      // R5 refresh spacing on a long high level
      din = 1'b1;
      t = nclk;
      k = 0;
      lows = 0;
      clr0 = n_clr;
      for (int i = 0; i < 700; i++) begin
         tick();
         if (pulse_set) begin
            if (k < 8) times[k] = nclk - t;
            k++;
         end
         if (!dout && (nclk - t) > M + 3) lows++;
      end
      check(times[0] == M + 2, "R2 edge pulse latency", times[0], M + 2);
      check(k == 4, "R5 pulse count on idle", k, 4);
      for (int j = 1; j < 4; j++)
         check(times[j] - times[j-1] == R, "R5 refresh spacing", times[j] - times[j-1], R);
      check(n_clr == clr0, "R5 no opposite refresh", n_clr - clr0, 0);
      check(lows == 0, "R3 dout holds high", lows, 0);

      // R8 watchdog after disabling the sender
      din = 1'b0;
      t = nclk;
      repeat (20) tick();
      check(dout == 1'b0, "R3 dout low", dout, 0);
      check(last_clr_t - t == M + 2, "R2 clear latency", last_clr_t - t, M + 2);
      tx_enable = 1'b0;
      lp = last_clr_t;
      pc = n_set + n_clr;
      while (nclk < lp + W) begin
         tick();
         if (nclk == lp + 30) din = 1'b1;
         if (nclk == lp + 80) din = 1'b0;
      end
      check(dout == 1'b0, "R8 dout before expiry", dout, 0);
      tick();
      check(dout == 1'b1, "R8 dout forced high", dout, 1);
      repeat (50) tick();
      check(n_set + n_clr == pc, "R7 no pulse while disabled", n_set + n_clr - pc, 0);
      check(dout == 1'b1, "R8 dout stays high", dout, 1);

      // R6 R9 re-enable onto an expired receiver
      tx_enable = 1'b1;
      te = nclk;
      repeat (R) tick();
      check(pulse_clr == 1'b1 && last_clr_t == te + R, "R6 refresh after enable", last_clr_t - te, R);
      check(n_set + n_clr == pc + 1, "R7 single pulse after enable", n_set + n_clr - pc, 1);
      tick();
      check(dout == 1'b0, "R9 clear after expiry", dout, 0);

      check(excl_cnt == 0, "R10 set and clear exclusive", excl_cnt, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule